// File: doc/BRIEF.md
# Two-Level LPC Interrupt Aggregator

This block collects interrupt sources from a low-pin-count host interface and folds them into one interrupt output. The first stage holds a sticky status word. Seventeen serial-IRQ level inputs, a link-reset event and eight bus-error / bus-master-request events set bits in this word. The status word is ANDed with a mask. The result is gated by a global enable bit in a serializer-control register, which produces one internal line.

The internal line appears as a single bit of a read-only input word in a second stage. That stage latches the input ANDed with its own mask into a second sticky status word. The interrupt output is high whenever that second status is nonzero. It therefore stays high after the source goes away, until software clears it.

Both stages are programmed through one 32-bit register port. A bank-select bit chooses between the two register windows. Evaluation is done every cycle, so no register write needs to re-trigger it.

Top module: `lpc_irq_aggregator`

## Requirements
- R1: After reset the firmware read-size register (bank 0, offset 0x28) reads 0x02000000. Every other implemented register reads 0, and `irq_o` is low.
- R2: Status bit (31 − n) is set by a high level on `ser_irq[n]`. The status register is bank 0, offset 0x38. The bit stays set after the input returns low.
- R3: `link_rst_evt` sets bank-0 status bit 10, and `err_evt[k]` sets bank-0 status bit k (k = 0..7). Writing a word to bank-0 status clears exactly the bits that are 1 in that word.
- R4: The internal line is high only when bit 31 of the serializer-control register (bank 0, 0x30) is set and (status AND mask) is nonzero. The mask is bank 0, 0x34. The line is visible as bit 11 of the bank-1 input register at 0x5C. All other bits of that register read 0.
- R5: Each cycle the bank-1 status register (0x50) ORs in (input AND bank-1 mask at 0x54). This becomes visible one cycle after the line rises. `irq_o` is high whenever bank-1 status is nonzero, and it stays high after the line drops.
- R6: Writing 1s to bank-1 status clears those bits. A bit whose masked input is still high in that cycle stays set.
- R7: The segment-select (bank 0, 0x24), read-size (0x28), route (bank 1, 0x08 and 0x0C) and polarity (bank 1, 0x58) registers store and return what was written. Polarity has no effect on `irq_o`.
- R8: Writes to the bank-1 input register and to the bank-0 error-address register (0x40) are ignored. The error-address register reads 0.
- R9: Reads of any other offset in either bank, including offsets that are not word-aligned, return 0xFFFFFFFF. Writes to those offsets change no register.
- R10: In bank-0 status, a set event wins over a software clear of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_bank | input | 1 | 0 selects the first-stage window, 1 the second-stage window |
| reg_addr | input | 8 | Byte offset within the selected window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_bank/reg_addr (combinational) |
| ser_irq | input | 17 | Serial-IRQ levels, index n maps to status bit 31−n |
| link_rst_evt | input | 1 | Link-reset event, sets status bit 10 |
| err_evt | input | 8 | Sync-error and bus-master request events, bit k sets status bit k |
| irq_o | output | 1 | Aggregated interrupt output |

## Verification
The hardest case to reach is a clear of a second-stage status bit while the first stage is still driving the line high. Only there does the re-latch priority show up. The stimulus gets there by setting a serial IRQ bit, enabling the first stage, and unmasking both stages. It then clears the second-stage status without touching the first stage, and only afterwards clears the first stage. That ordering separates "re-latched while the line is high" from "sticky after the line drops". A similar same-cycle collision drives a serial IRQ high while software clears the same first-stage bit.

// File: rtl/lpc_irq_aggregator.sv
module lpc_irq_aggregator #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int NSER       = 17,
  parameter int NERR       = 8,
  parameter int EN_BIT     = 31,
  parameter int LRST_BIT   = 10,
  parameter int LINE_BIT   = 11,
  parameter logic [31:0] RDSIZE_RST = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_bank,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSER-1:0]   ser_irq,
  input  logic              link_rst_evt,
  input  logic [NERR-1:0]   err_evt,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] OFS_SEG    = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] OFS_RDSZ   = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] OFS_MASK1  = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] OFS_STAT1  = ADDR_W'('h38);
  localparam logic [ADDR_W-1:0] OFS_ERRA   = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] OFS_ROUTE0 = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_ROUTE1 = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_STAT2  = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] OFS_MASK2  = ADDR_W'('h54);
  localparam logic [ADDR_W-1:0] OFS_POL    = ADDR_W'('h58);
  localparam logic [ADDR_W-1:0] OFS_IN2    = ADDR_W'('h5C);

  logic [DATA_W-1:0] seg_q, rdsz_q, ctrl_q, mask1_q, stat1_q;
  logic [DATA_W-1:0] route0_q, route1_q, stat2_q, mask2_q, pol_q;
  logic [DATA_W-1:0] set1, in2;
  logic              line;

  wire wr0 = reg_we & ~reg_bank;
  wire wr1 = reg_we &  reg_bank;
  wire wr_stat1 = wr0 && (reg_addr == OFS_STAT1);
  wire wr_stat2 = wr1 && (reg_addr == OFS_STAT2);

  always_comb begin
    set1 = '0;
    for (int i = 0; i < NSER; i++) set1[DATA_W-1-i] = ser_irq[i];
    set1[LRST_BIT] = set1[LRST_BIT] | link_rst_evt;
    set1[NERR-1:0] = set1[NERR-1:0] | err_evt;
  end

  assign line  = ctrl_q[EN_BIT] & (|(stat1_q & mask1_q));
  assign in2   = DATA_W'(line) << LINE_BIT;
  assign irq_o = |stat2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= '0;
      rdsz_q   <= DATA_W'(RDSIZE_RST);
      ctrl_q   <= '0;
      mask1_q  <= '0;
      stat1_q  <= '0;
      route0_q <= '0;
      route1_q <= '0;
      stat2_q  <= '0;
      mask2_q  <= '0;
      pol_q    <= '0;
    end else begin
      if (wr0 && reg_addr == OFS_SEG)    seg_q    <= reg_wdata;
      if (wr0 && reg_addr == OFS_RDSZ)   rdsz_q   <= reg_wdata;
      if (wr0 && reg_addr == OFS_CTRL)   ctrl_q   <= reg_wdata;
      if (wr0 && reg_addr == OFS_MASK1)  mask1_q  <= reg_wdata;
      if (wr1 && reg_addr == OFS_ROUTE0) route0_q <= reg_wdata;
      if (wr1 && reg_addr == OFS_ROUTE1) route1_q <= reg_wdata;
      if (wr1 && reg_addr == OFS_MASK2)  mask2_q  <= reg_wdata;
      if (wr1 && reg_addr == OFS_POL)    pol_q    <= reg_wdata;
      stat1_q <= (stat1_q & ~(wr_stat1 ? reg_wdata : '0)) | set1;
      stat2_q <= (stat2_q & ~(wr_stat2 ? reg_wdata : '0)) | (in2 & mask2_q);
    end
  end

  always_comb begin
    reg_rdata = '1;
    if (!reg_bank) begin
      case (reg_addr)
        OFS_SEG:   reg_rdata = seg_q;
        OFS_RDSZ:  reg_rdata = rdsz_q;
        OFS_CTRL:  reg_rdata = ctrl_q;
        OFS_MASK1: reg_rdata = mask1_q;
        OFS_STAT1: reg_rdata = stat1_q;
        OFS_ERRA:  reg_rdata = '0;
        default:   reg_rdata = '1;
      endcase
    end else begin
      case (reg_addr)
        OFS_ROUTE0: reg_rdata = route0_q;
        OFS_ROUTE1: reg_rdata = route1_q;
        OFS_STAT2:  reg_rdata = stat2_q;
        OFS_MASK2:  reg_rdata = mask2_q;
        OFS_POL:    reg_rdata = pol_q;
        OFS_IN2:    reg_rdata = in2;
        default:    reg_rdata = '1;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NSER; g++) begin : g_ser_chk
      // R2
      ser_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_irq[g] |=> stat1_q[DATA_W-1-g]);
    end
  endgenerate

  // R3
  stat1_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat1 && reg_wdata[LRST_BIT] && !link_rst_evt) |=> !stat1_q[LRST_BIT]);

  // R4
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ctrl_q[EN_BIT] && mask2_q[LINE_BIT] && (|(stat1_q & mask1_q))));

  // R5
  stat2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat2_q[LINE_BIT] && !(wr_stat2 && reg_wdata[LINE_BIT])) |=> stat2_q[LINE_BIT]);

  // R6
  stat2_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat2 && reg_wdata[LINE_BIT] && !(line && mask2_q[LINE_BIT])) |=> !stat2_q[LINE_BIT]);

endmodule

// File: tb/lpc_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module lpc_irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_bank = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [16:0] ser_irq = '0;
  logic        link_rst_evt = 1'b0;
  logic [7:0]  err_evt = '0;
  logic        irq_o;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  lpc_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_bank(reg_bank),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_irq(ser_irq), .link_rst_evt(link_rst_evt), .err_evt(err_evt),
    .irq_o(irq_o));

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%08h exp=%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_bank = b; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic b, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_bank = b; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
  endtask

  task automatic pulse_ser(input int n);
    @(negedge clk); ser_irq[n] = 1'b1;
    @(negedge clk); ser_irq[n] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 8'h28, d); chk("R1", "rdsize reset", d, 32'h0200_0000);
    rd(0, 8'h24, d); chk("R1", "seg reset", d, 0);
    rd(0, 8'h30, d); chk("R1", "ctrl reset", d, 0);
    rd(0, 8'h38, d); chk("R1", "stat1 reset", d, 0);
    rd(1, 8'h50, d); chk("R1", "stat2 reset", d, 0);
    rd(1, 8'h54, d); chk("R1", "mask2 reset", d, 0);
    chk("R1", "irq_o reset", 32'(irq_o), 0);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    rd(0, 8'h00, d); chk("R9", "bank0 0x00", d, 32'hFFFF_FFFF);
    rd(1, 8'h10, d); chk("R9", "bank1 0x10", d, 32'hFFFF_FFFF);
    rd(0, 8'h25, d); chk("R9", "misaligned 0x25", d, 32'hFFFF_FFFF);
    rd(1, 8'h24, d); chk("R9", "bank1 0x24", d, 32'hFFFF_FFFF);
    wr(0, 8'h3C, 32'h0000_5555);
    wr(1, 8'h30, 32'h8000_0000);
    rd(0, 8'h3C, d); chk("R9", "0x3C after write", d, 32'hFFFF_FFFF);
    rd(0, 8'h30, d); chk("R9", "ctrl untouched", d, 0);
    rd(0, 8'h34, d); chk("R9", "mask1 untouched", d, 0);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    wr(0, 8'h24, 32'h1234_5678);
    wr(0, 8'h28, 32'h0700_0000);
    wr(1, 8'h08, 32'hA5A5_0001);
    wr(1, 8'h0C, 32'h5A5A_0002);
    wr(1, 8'h58, 32'hDEAD_BEEF);
    rd(0, 8'h24, d); chk("R7", "seg", d, 32'h1234_5678);
    rd(0, 8'h28, d); chk("R7", "rdsize", d, 32'h0700_0000);
    rd(1, 8'h08, d); chk("R7", "route0", d, 32'hA5A5_0001);
    rd(1, 8'h0C, d); chk("R7", "route1", d, 32'h5A5A_0002);
    rd(1, 8'h58, d); chk("R7", "polarity", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_serirq();
    logic [31:0] d;
    pulse_ser(0);
    rd(0, 8'h38, d); chk("R2", "ser0 -> bit31 sticky", d, 32'h8000_0000);
    pulse_ser(16);
    rd(0, 8'h38, d); chk("R2", "ser16 -> bit15", d, 32'h8000_8000);
    wr(0, 8'h38, 32'h8000_0000);
    rd(0, 8'h38, d); chk("R3", "w1c bit31 only", d, 32'h0000_8000);
    wr(0, 8'h38, 32'hFFFF_FFFF);
    rd(0, 8'h38, d); chk("R3", "w1c all", d, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    @(negedge clk); link_rst_evt = 1'b1; err_evt = 8'h81;
    @(negedge clk); link_rst_evt = 1'b0; err_evt = 8'h00;
    rd(0, 8'h38, d); chk("R3", "events -> bits 10,7,0", d, 32'h0000_0481);
    wr(0, 8'h38, 32'h0000_0401);
    rd(0, 8'h38, d); chk("R3", "partial clear", d, 32'h0000_0080);
    wr(0, 8'h38, 32'h0000_0080);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    pulse_ser(3);
    @(negedge clk);
    ser_irq[3] = 1'b1;
    reg_we = 1'b1; reg_bank = 1'b0; reg_addr = 8'h38; reg_wdata = 32'h1000_0000;
    @(posedge clk); #1;
    reg_we = 1'b0; ser_irq[3] = 1'b0;
    rd(0, 8'h38, d); chk("R10", "set wins over clear", d, 32'h1000_0000);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(0, 8'h34, 32'hFFFF_8000);
    rd(1, 8'h5C, d); chk("R4", "line low while disabled", d, 0);
    wr(0, 8'h34, 32'h0000_0400);
    wr(0, 8'h30, 32'h8000_0000);
    rd(1, 8'h5C, d); chk("R4", "line low, bit masked", d, 0);
    wr(0, 8'h34, 32'hFFFF_8000);
    rd(1, 8'h5C, d); chk("R4", "line high", d, 32'h0000_0800);
    settle();
    chk("R5", "irq_o low with mask2=0", 32'(irq_o), 0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    wr(1, 8'h54, 32'h0000_0800);
    settle();
    rd(1, 8'h50, d); chk("R5", "stat2 latched", d, 32'h0000_0800);
    chk("R5", "irq_o high", 32'(irq_o), 1);
    wr(1, 8'h50, 32'h0000_0800);
    settle();
    rd(1, 8'h50, d); chk("R6", "re-latch while line high", d, 32'h0000_0800);
    wr(0, 8'h38, 32'h1000_0000);
    settle();
    rd(1, 8'h5C, d); chk("R4", "line dropped", d, 0);
    chk("R5", "irq_o sticky after line drop", 32'(irq_o), 1);
    wr(1, 8'h50, 32'h0000_0800);
    settle();
    rd(1, 8'h50, d); chk("R6", "stat2 cleared", d, 0);
    chk("R6", "irq_o low after clear", 32'(irq_o), 0);
  endtask

  task automatic t_pol();
    logic [31:0] d;
    wr(1, 8'h58, 32'hFFFF_FFFF);
    settle();
    chk("R7", "polarity no effect idle", 32'(irq_o), 0);
    pulse_ser(5);
    settle();
    chk("R7", "polarity no effect active", 32'(irq_o), 1);
    wr(0, 8'h38, 32'hFFFF_FFFF);
    wr(1, 8'h50, 32'hFFFF_FFFF);
    settle();
    rd(1, 8'h50, d); chk("R6", "stat2 clear all", d, 0);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    wr(1, 8'h5C, 32'hFFFF_FFFF);
    rd(1, 8'h5C, d); chk("R8", "input reg write ignored", d, 0);
    wr(0, 8'h40, 32'h1234_0000);
    rd(0, 8'h40, d); chk("R8", "error addr write ignored", d, 0);
    settle();
    chk("R8", "irq_o unaffected", 32'(irq_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_unimpl();
    t_storage();
    t_serirq();
    t_events();
    t_setwins();
    t_gate();
    t_latch();
    t_pol();
    t_ro();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule